// File: doc/BRIEF.md
# Bunch-by-Bunch Longitudinal Phase Damper

This block sits between a bunch phase detector and the DAC that drives a broadband damping cavity. Each accepted sample carries one signed 14-bit phase value for one bunch, the index of that bunch, and a marker that flags the first sample of a new revolution turn. The block keeps an eight-turn history of phase values for every bunch. For each incoming sample it updates that bunch's history and applies an eight-tap difference filter across turns, which gives an estimate of how fast the bunch's phase is drifting.

The filter output is compared against a symmetric threshold. A bunch drifting later by more than the threshold is given a fixed negative kick. A bunch drifting earlier by more than the threshold is given a fixed positive kick. A bunch inside the dead band is given no kick. The kick is a 12-bit signed word with a per-bunch valid strobe and the bunch index. It appears a fixed number of cycles after the sample. A two-state controller holds every kick at zero until a full eight turns of history exist after reset or after a history clear. The state ST_FILL counts turn markers. It moves to ST_RUN on the eighth counted marker. It returns to ST_FILL with its count at zero on a clear, whether it was in ST_FILL or ST_RUN.

Top module: `bunch_phase_damper`

## Requirements
- R1: While reset is asserted and after its release, until a sample is accepted, kick_valid is 0 and kick_value is 0.
- R2: An accepted sample produces kick_valid=1 with kick_bunch equal to its bunch index exactly 3 clock cycles after the cycle in which it is presented. Nothing is produced in the cycles in between.
- R3: A sample whose bunch index is not below cfg_nbunch (or not below MAX_BUNCH) is ignored. It produces no kick_valid, and its turn marker is not counted.
- R4: Each bunch has its own eight-turn history. Samples for one bunch do not alter the kick computed for another bunch.
- R5: The derivative D for a sample is the sum of that bunch's four newest phases (this turn and the three before) minus the sum of the four phases before those.
- R6: If D > cfg_thresh, kick_value is -cfg_kick in 12-bit two's complement.
- R7: If D < -cfg_thresh, kick_value is +cfg_kick.
- R8: If -cfg_thresh <= D <= cfg_thresh, kick_value is 0. Both boundaries fall inside the dead band.
- R9: A turn marker counts when it comes with an accepted sample. Samples before the eighth counted marker since reset or clear give kick_value 0. The sample carrying the eighth marker, and every later sample, is filtered.
- R10: clr_hist returns the controller to ST_FILL with a count of zero. A sample in the same cycle gives kick_value 0 and its marker is not counted.
- R11: D is exact over the full phase range. Four newest samples at +8191 and four oldest at -8192 give D=65532.
- R12: Samples for the same bunch on consecutive clock cycles each see the history written by the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_hist | input | 1 | Restart history fill (one-cycle pulse) |
| smp_valid | input | 1 | Phase sample present this cycle |
| smp_turn | input | 1 | Sample is the first of a new turn |
| smp_bunch | input | 10 | Bunch index of the sample |
| smp_phase | input | 14 | Signed bunch phase |
| cfg_nbunch | input | 10 | Number of bunches per turn |
| cfg_thresh | input | 16 | Unsigned dead-band half-width on D |
| cfg_kick | input | 11 | Unsigned kick magnitude |
| kick_valid | output | 1 | Kick word present |
| kick_bunch | output | 10 | Bunch index of the kick |
| kick_value | output | 12 | Signed kick: +cfg_kick, -cfg_kick or 0 |

## Verification
The assertions assume that cfg_kick and cfg_thresh do not change while a sample is in flight. They also assume that a turn marker comes only with a sample. The stimulus changes configuration only when the pipeline is empty, and it pulses clr_hist only between samples or together with a sample the bench treats as uncounted. Phase trajectories are linear ramps and full-scale steps, so the expected derivative is a closed form of the slope (sixteen times the slope for a ramp).

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_st_e;

    // +1 weight for the newer half of the taps, -1 for the older half
    function automatic bit tap_is_new(input int k, input int taps);
        return (k < taps / 2);
    endfunction

endpackage

// File: rtl/dmp_fill_ctrl.sv
module dmp_fill_ctrl
    import dmp_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int CW = $clog2(TAPS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic acc,
    input  logic turn,
    output logic hist_ok
);

    fill_st_e        st, st_n;
    logic [CW-1:0]   fcnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = fcnt;
        unique case (st)
            ST_FILL: begin
                if (clr) begin
                    cnt_n = '0;
                end else if (acc && turn) begin
                    if (fcnt == CW'(TAPS - 1)) begin
                        st_n  = ST_RUN;
                        cnt_n = CW'(TAPS);
                    end else begin
                        cnt_n = fcnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (clr) begin
                    st_n  = ST_FILL;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_FILL;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_FILL;
            fcnt <= '0;
        end else begin
            st   <= st_n;
            fcnt <= cnt_n;
        end
    end

    always_comb begin
        hist_ok = 1'b0;
        if (acc && !clr) begin
            unique case (st)
                ST_RUN:  hist_ok = 1'b1;
                ST_FILL: hist_ok = turn && (fcnt == CW'(TAPS - 1));
                default: hist_ok = 1'b0;
            endcase
        end
    end

    // R10
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st == ST_FILL) && (fcnt == '0));

    // R9
    run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (fcnt == CW'(TAPS)));

endmodule

// File: rtl/dmp_hist_fir.sv
module dmp_hist_fir
    import dmp_pkg::*;
#(
    parameter int NB    = 588,
    parameter int PH_W  = 14,
    parameter int TAPS  = 8,
    parameter int BW    = 10,
    localparam int DER_W  = PH_W + $clog2(TAPS),
    localparam int LINE_W = TAPS * PH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BW-1:0]           in_bunch,
    input  logic signed [PH_W-1:0]  in_phase,
    input  logic                    in_ok,
    output logic                    out_valid,
    output logic [BW-1:0]           out_bunch,
    output logic                    out_ok,
    output logic signed [DER_W-1:0] out_deriv
);

    logic                   s1_valid, s1_ok;
    logic [BW-1:0]          s1_bunch;
    logic signed [PH_W-1:0] s1_phase;

    logic [LINE_W-1:0] hist_mem [NB];
    logic [LINE_W-1:0] old_line, new_line;
    logic signed [DER_W-1:0] tap_w [TAPS];
    logic signed [DER_W-1:0] dsum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ok    <= 1'b0;
            s1_bunch <= '0;
            s1_phase <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_ok    <= in_ok;
            s1_bunch <= in_bunch;
            s1_phase <= in_phase;
        end
    end

    assign old_line = hist_mem[s1_bunch];
    assign new_line = {old_line[LINE_W-PH_W-1:0], s1_phase};

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (tap_is_new(k, TAPS)) begin : g_pos
            assign tap_w[k] = DER_W'($signed(new_line[k*PH_W +: PH_W]));
        end else begin : g_neg
            assign tap_w[k] = -DER_W'($signed(new_line[k*PH_W +: PH_W]));
        end
    end

    always_comb begin
        dsum = '0;
        for (int k = 0; k < TAPS; k++) begin
            dsum = dsum + tap_w[k];
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            hist_mem[s1_bunch] <= new_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ok    <= 1'b0;
            out_bunch <= '0;
            out_deriv <= '0;
        end else begin
            out_valid <= s1_valid;
            out_ok    <= s1_ok;
            out_bunch <= s1_bunch;
            out_deriv <= dsum;
        end
    end

    // R3
    hist_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_bunch < BW'(NB)));

endmodule

// File: rtl/dmp_kick_slice.sv
module dmp_kick_slice #(
    parameter int DER_W = 17,
    parameter int KW    = 12,
    parameter int BW    = 10,
    localparam int TH_W = DER_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BW-1:0]           in_bunch,
    input  logic                    in_ok,
    input  logic signed [DER_W-1:0] in_deriv,
    input  logic [TH_W-1:0]         thr,
    input  logic [KW-2:0]           amp,
    output logic                    kick_valid,
    output logic [BW-1:0]           kick_bunch,
    output logic signed [KW-1:0]    kick_value
);

    logic signed [DER_W:0] dx, tx, ntx;
    logic signed [KW-1:0]  pamp, namp, kick_n;
    logic                  go_pos, go_neg;

    assign dx   = {in_deriv[DER_W-1], in_deriv};
    assign tx   = $signed({2'b00, thr});
    assign ntx  = -tx;
    assign pamp = $signed({1'b0, amp});
    assign namp = -pamp;

    assign go_neg = in_ok && (dx > tx);
    assign go_pos = in_ok && (dx < ntx);

    always_comb begin
        kick_n = '0;
        if (go_neg) begin
            kick_n = namp;
        end else if (go_pos) begin
            kick_n = pamp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_valid <= 1'b0;
            kick_bunch <= '0;
            kick_value <= '0;
        end else begin
            kick_valid <= in_valid;
            kick_bunch <= in_bunch;
            kick_value <= in_valid ? kick_n : '0;
        end
    end

    // R6
    late_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ok && (dx > tx)) |=> (kick_value == -$signed({1'b0, $past(amp)})));

    // R7
    early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ok && (dx < ntx)) |=> (kick_value == $signed({1'b0, $past(amp)})));

    // R8
    dead_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!in_ok || ((dx <= tx) && (dx >= ntx)))) |=> (kick_value == '0));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_valid |-> (kick_value == '0));

endmodule

// File: rtl/bunch_phase_damper.sv
module bunch_phase_damper #(
    parameter int MAX_BUNCH = 588,
    parameter int PH_W      = 14,
    parameter int TAPS      = 8,
    parameter int KW        = 12,
    localparam int BW    = $clog2(MAX_BUNCH + 1),
    localparam int DER_W = PH_W + $clog2(TAPS),
    localparam int TH_W  = DER_W - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_hist,
    input  logic                   smp_valid,
    input  logic                   smp_turn,
    input  logic [BW-1:0]          smp_bunch,
    input  logic signed [PH_W-1:0] smp_phase,
    input  logic [BW-1:0]          cfg_nbunch,
    input  logic [TH_W-1:0]        cfg_thresh,
    input  logic [KW-2:0]          cfg_kick,
    output logic                   kick_valid,
    output logic [BW-1:0]          kick_bunch,
    output logic signed [KW-1:0]   kick_value
);

    logic                    accept, hist_ok;
    logic                    d_valid, d_ok;
    logic [BW-1:0]           d_bunch;
    logic signed [DER_W-1:0] d_deriv;

    assign accept = smp_valid && (smp_bunch < cfg_nbunch) && (smp_bunch < BW'(MAX_BUNCH));

    dmp_fill_ctrl #(.TAPS(TAPS)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_hist),
        .acc     (accept),
        .turn    (smp_turn),
        .hist_ok (hist_ok)
    );

    dmp_hist_fir #(.NB(MAX_BUNCH), .PH_W(PH_W), .TAPS(TAPS), .BW(BW)) u_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept),
        .in_bunch  (smp_bunch),
        .in_phase  (smp_phase),
        .in_ok     (hist_ok),
        .out_valid (d_valid),
        .out_bunch (d_bunch),
        .out_ok    (d_ok),
        .out_deriv (d_deriv)
    );

    dmp_kick_slice #(.DER_W(DER_W), .KW(KW), .BW(BW)) u_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (d_valid),
        .in_bunch   (d_bunch),
        .in_ok      (d_ok),
        .in_deriv   (d_deriv),
        .thr        (cfg_thresh),
        .amp        (cfg_kick),
        .kick_valid (kick_valid),
        .kick_bunch (kick_bunch),
        .kick_value (kick_value)
    );

    // R3
    kick_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_valid |-> (kick_bunch < BW'(MAX_BUNCH)));

endmodule

// File: tb/sim_bunch_phase_damper.sv
module sim_bunch_phase_damper;

    localparam int NV = 9;
    // slope per turn, threshold, kick magnitude, expected sign (-1/0/+1)
    localparam int TBL [NV][4] = '{
        '{  10,   100, 2047, -1},
        '{ -10,   100, 2047,  1},
        '{   6,   100,  300,  0},
        '{   0,     0,    5,  0},
        '{   1,    16,   77,  0},
        '{   1,    15,   77, -1},
        '{  -1,    16,   77,  0},
        '{  -1,    15,   77,  1},
        '{ 500, 65535, 1000,  0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, sv = 1'b0, st = 1'b0;
    logic [9:0] sb = '0, nb = 10'd1;
    logic signed [13:0] sp = '0;
    logic [15:0] thr = '0;
    logic [10:0] amp = '0;
    logic kv;
    logic [9:0] kb;
    logic signed [11:0] kval;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bunch_phase_damper u0 (
        .clk(clk), .rst_n(rst_n), .clr_hist(clr),
        .smp_valid(sv), .smp_turn(st), .smp_bunch(sb), .smp_phase(sp),
        .cfg_nbunch(nb), .cfg_thresh(thr), .cfg_kick(amp),
        .kick_valid(kv), .kick_bunch(kb), .kick_value(kval)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic send(input int b, input int ph, input bit trn, input bit cl,
                        input bit expv, input int expk, input string req);
        @(negedge clk);
        sv = 1'b1; sb = 10'(b); sp = 14'(ph); st = trn; clr = cl;
        @(negedge clk);
        sv = 1'b0; st = 1'b0; clr = 1'b0;
        @(negedge clk);
        chk(kv == 1'b0, "R2 early", int'(kv), 0);
        @(negedge clk);
        if (expv) begin
            chk(kv == 1'b1 && kb == 10'(b), {req, " R2 bunch"}, int'(kb), b);
            chk(int'(kval) == expk, req, int'(kval), expk);
        end else begin
            chk(kv == 1'b0, req, int'(kv), 0);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(kv == 1'b0 && kval == '0, "R1 in reset", int'(kval), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(kv == 1'b0 && kval == '0, "R1 after reset", int'(kval), 0);

        // Table: linear ramps on one bunch, D = 16*slope on the 8th turn (R5)
        nb = 10'd1;
        for (int i = 0; i < NV; i++) begin
            thr = 16'(TBL[i][1]);
            amp = 11'(TBL[i][2]);
            do_clear();
            for (int t = 0; t < 8; t++) begin
                if (t < 7) begin
                    send(0, 100 + TBL[i][0] * t, 1'b1, 1'b0, 1'b1, 0, "R9 fill");
                end else begin
                    send(0, 100 + TBL[i][0] * t, 1'b1, 1'b0, 1'b1, TBL[i][3] * TBL[i][2],
                         TBL[i][3] < 0 ? "R5 R6" : (TBL[i][3] > 0 ? "R5 R7" : "R5 R8"));
                end
            end
        end

        // R10: clear with a simultaneous sample; that marker is not counted
        thr = 16'd100; amp = 11'd400;
        send(0, 0, 1'b1, 1'b1, 1'b1, 0, "R10 clear sample");
        for (int t = 1; t < 8; t++) begin
            send(0, -20 * t, 1'b1, 1'b0, 1'b1, 0, "R10 refill");
        end
        send(0, -160, 1'b1, 1'b0, 1'b1, 400, "R10 run");

        // R3: out-of-range bunch is ignored and its marker does not count
        nb = 10'd2; thr = 16'd0; amp = 11'd50;
        send(2, 1234, 1'b0, 1'b0, 1'b0, 0, "R3 ignored");
        do_clear();
        nb = 10'd1;
        for (int t = 0; t < 6; t++) begin
            send(0, -200 * t, 1'b1, 1'b0, 1'b1, 0, "R9 fill");
        end
        send(1, 5000, 1'b1, 1'b0, 1'b0, 0, "R3 ignored marker");
        send(0, -1200, 1'b1, 1'b0, 1'b1, 0, "R3 marker not counted");

        // R4: three bunches with opposite drifts
        nb = 10'd3; thr = 16'd50; amp = 11'd300;
        do_clear();
        for (int t = 0; t < 8; t++) begin
            send(0, 10 * t, 1'b1, 1'b0, 1'b1, t == 7 ? -300 : 0, "R4 b0");
            send(1, -10 * t, 1'b0, 1'b0, 1'b1, t == 7 ? 300 : 0, "R4 b1");
            send(2, 33, 1'b0, 1'b0, 1'b1, 0, "R4 b2");
        end

        // R11: full-scale steps
        nb = 10'd1; thr = 16'd65531; amp = 11'd2047;
        do_clear();
        for (int t = 0; t < 12; t++) begin
            int ph, ek;
            ph = (t < 4 || t >= 8) ? -8192 : 8191;
            ek = (t == 7) ? -2047 : ((t == 11) ? 2047 : 0);
            send(0, ph, 1'b1, 1'b0, 1'b1, ek, "R11 full scale");
        end

        // R12: back-to-back samples of one bunch
        thr = 16'd100; amp = 11'd123;
        do_clear();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk(kv == 1'b1 && kb == 10'd0, "R12 valid", int'(kv), 1);
                chk(int'(kval) == ((i - 3) >= 7 ? 123 : 0), "R12 stream",
                    int'(kval), (i - 3) >= 7 ? 123 : 0);
            end
            if (i < 9) begin
                sv = 1'b1; st = 1'b1; sb = 10'd0; sp = 14'(-10 * i);
            end else begin
                sv = 1'b0; st = 1'b0;
            end
        end

        report();
    end

endmodule